// File: doc/BRIEF.md
# Ultrasonic Ranging Sensor Emulator

This block stands in for a trigger/echo ultrasonic distance sensor, so that a ranging controller can be exercised in simulation or on a board with no transducer attached. It watches a trigger line and measures how long each pulse stays high. A pulse that is long enough starts a measurement when it falls. The block first plays a short burst of 40 kHz transmit tones on a monitor output. It then raises the echo line for the round-trip time of sound to a virtual obstacle.

The obstacle distance is an input, either in centimetres or in inches. A separate input selects an empty scene, in which case the echo runs for a fixed timeout. The block ignores triggers that arrive too soon after a measurement has started. A busy flag and a one-clock completion strobe let a testbench or an on-chip monitor follow each measurement. All microsecond timing derives from a free-running prescaler on the system clock.

Top module: `ultra_echo_emu`

## Requirements
- R1: After reset, echoOut, txTone, busy and measDone are all low.
- R2: A trigger pulse that stays high for at least MIN_TRIG_US (10) microseconds is accepted on its falling edge. A shorter pulse starts nothing, and busy stays low.
- R3: On acceptance, busy and txTone rise together. txTone then produces exactly TONE_CYCLES (8) square cycles. Each cycle starts high and is high for TONE_HALF_CLK clocks and low for TONE_HALF_CLK clocks (625 clocks each way at 50 MHz, which gives 40 kHz). During the burst txTone is high for a total of TONE_CYCLES*TONE_HALF_CLK clocks.
- R4: In centimetre mode (unitInch = 0), echoOut rises on the clock after the burst ends. It stays high for exactly distIn*58*CLK_PER_US clocks.
- R5: In inch mode (unitInch = 1), echoOut stays high for exactly distIn*148*CLK_PER_US clocks.
- R6: When noObstacle = 1 at acceptance, echoOut stays high for TIMEOUT_US*CLK_PER_US clocks (38 ms by default), whatever the distance.
- R7: distIn, unitInch and noObstacle are sampled at acceptance. Changing them during a measurement does not change that measurement's echo width.
- R8: A trigger is ignored if it arrives while busy is high, or less than GUARD_US (60000) microseconds after the previous accepted trigger.
- R9: A rejected short trigger does not restart the guard interval. A valid trigger that comes after the guard from the last accepted trigger has run out is accepted.
- R10: busy stays high from acceptance until echoOut falls, and both fall on the same clock. measDone is high for exactly one clock, the first clock in which echoOut is low again.
- R11: A distance of 0 is treated as a distance of 1 unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz by default) |
| rstN | input | 1 | Asynchronous active-low reset |
| trigIn | input | 1 | Trigger from the ranging controller (asynchronous) |
| distIn | input | DIST_W | Obstacle distance in the selected unit |
| unitInch | input | 1 | 0 selects centimetres, 1 selects inches |
| noObstacle | input | 1 | 1 selects the empty-scene echo timeout |
| echoOut | output | 1 | Echo pulse; its width encodes the distance |
| txTone | output | 1 | Monitor copy of the transmit burst |
| busy | output | 1 | A measurement is in progress |
| measDone | output | 1 | One-clock strobe after the echo ends |

## Verification
The bench measures echo width exactly in clocks for both units, for the timeout case and for a zero distance. A wrong scale factor, a missing clamp or an off-by-one in the echo counter would each show up as a width error of at least one clock.

It also targets the trigger filter. It sends a pulse too short to count, a valid pulse during a measurement, and a valid pulse during the guard interval; a design that accepted any of them would raise busy when it should not. It then sends a short pulse and follows it with a valid trigger that is only legal if the guard was not restarted; a design that reset the guard on every edge would drop that trigger.

Finally, it changes the distance and unit in the middle of a measurement. A design that read the inputs live instead of latching them would produce a different echo width.

// File: rtl/ultra_pkg.sv
package ultra_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BURST = 2'd1,
    ST_ECHO  = 2'd2
  } ctrlState_t;

  typedef struct packed {
    logic accept;     // trigger accepted: latch inputs, start the burst
    logic loadEcho;   // burst finished: load the echo counter
    logic countEcho;  // echo phase: count down
  } ctrlStb_t;
endpackage

// File: rtl/ultra_tick.sv
module ultra_tick #(
  parameter int CLK_PER_US = 50
) (
  input  logic clk,
  input  logic rstN,
  output logic usTick
);
  localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLK_PER_US - 1);

  logic [PW-1:0] preCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               preCnt <= '0;
    else if (preCnt == LAST) preCnt <= '0;
    else                     preCnt <= preCnt + 1'b1;
  end

  assign usTick = (preCnt == LAST);
endmodule

// File: rtl/ultra_ctrl.sv
module ultra_ctrl
  import ultra_pkg::*;
#(
  parameter int MIN_TRIG_US = 10,
  parameter int GUARD_US    = 60000
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     usTick,
  input  logic     trigIn,
  input  logic     burstDone,
  input  logic     echoLast,
  output ctrlStb_t stb,
  output logic     busy,
  output logic     echoOn,
  output logic     doneStb
);
  localparam int WW = $clog2(MIN_TRIG_US + 1);
  localparam int GW = $clog2(GUARD_US + 1);

  ctrlState_t state, stateNx;
  logic trigS1, trigS2, trigD;
  logic trigRise, trigFall;
  logic [WW-1:0] widthCnt;
  logic widthOk;
  logic [GW-1:0] guardCnt;
  logic guardIdle;

  // two-flop synchronizer plus an edge-detect stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigS1 <= 1'b0;
      trigS2 <= 1'b0;
      trigD  <= 1'b0;
    end else begin
      trigS1 <= trigIn;
      trigS2 <= trigS1;
      trigD  <= trigS2;
    end
  end

  assign trigRise = trigS2 & ~trigD;
  assign trigFall = ~trigS2 & trigD;
  assign widthOk  = (widthCnt >= WW'(MIN_TRIG_US));

  // pulse width in microseconds, saturating at the minimum
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             widthCnt <= '0;
    else if (trigRise)                     widthCnt <= '0;
    else if (trigS2 && usTick && !widthOk) widthCnt <= widthCnt + 1'b1;
  end

  assign guardIdle  = (guardCnt == '0);
  assign stb.accept = trigFall && widthOk && (state == ST_IDLE) && guardIdle;

  // only an accepted trigger restarts the guard interval
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        guardCnt <= '0;
    else if (stb.accept)              guardCnt <= GW'(GUARD_US);
    else if (usTick && !guardIdle)    guardCnt <= guardCnt - 1'b1;
  end

  always_comb begin
    stateNx = state;
    unique case (state)
      ST_IDLE:  if (stb.accept) stateNx = ST_BURST;
      ST_BURST: if (burstDone)  stateNx = ST_ECHO;
      ST_ECHO:  if (echoLast)   stateNx = ST_IDLE;
      default:  stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      doneStb <= 1'b0;
    end else begin
      state   <= stateNx;
      doneStb <= (state == ST_ECHO) && echoLast;
    end
  end

  assign stb.loadEcho  = (state == ST_BURST) && burstDone;
  assign stb.countEcho = (state == ST_ECHO);
  assign busy          = (state != ST_IDLE);
  assign echoOn        = (state == ST_ECHO);
endmodule

// File: rtl/ultra_dpath.sv
module ultra_dpath
  import ultra_pkg::*;
#(
  parameter int DIST_W        = 9,
  parameter int CLK_PER_US    = 50,
  parameter int TONE_HALF_CLK = 625,
  parameter int TONE_CYCLES   = 8,
  parameter int CM_US         = 58,
  parameter int IN_US         = 148,
  parameter int TIMEOUT_US    = 38000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [DIST_W-1:0] distIn,
  input  logic              unitInch,
  input  logic              noObstacle,
  output logic              txTone,
  output logic              burstDone,
  output logic              echoLast
);
  localparam int DIST_MAX = (1 << DIST_W) - 1;
  localparam int MAX_UNIT = (IN_US > CM_US) ? IN_US : CM_US;
  localparam int MAX_DCLK = DIST_MAX * MAX_UNIT * CLK_PER_US;
  localparam int TO_CLK   = TIMEOUT_US * CLK_PER_US;
  localparam int MAX_CLK  = (MAX_DCLK > TO_CLK) ? MAX_DCLK : TO_CLK;
  localparam int EW       = $clog2(MAX_CLK + 1);
  localparam int HALF_N   = 2 * TONE_CYCLES;
  localparam int TW       = $clog2(TONE_HALF_CLK + 1);
  localparam int HW       = $clog2(HALF_N + 1);

  logic [EW-1:0]     perUnit, targetClk, echoLoad, echoCnt;
  logic [DIST_W-1:0] distEff;
  logic [TW-1:0]     toneClk;
  logic [HW-1:0]     halfIdx;
  logic              toneActive, halfEnd;

  assign distEff   = (distIn == '0) ? DIST_W'(1) : distIn;
  assign perUnit   = unitInch ? EW'(IN_US * CLK_PER_US) : EW'(CM_US * CLK_PER_US);
  assign targetClk = noObstacle ? EW'(TO_CLK) : EW'(distEff) * perUnit;

  // echo length is fixed at acceptance
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           echoLoad <= '0;
    else if (stb.accept) echoLoad <= targetClk;
  end

  // transmit tone burst
  assign halfEnd   = toneActive && (toneClk == TW'(TONE_HALF_CLK - 1));
  assign burstDone = halfEnd && (halfIdx == HW'(HALF_N - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toneActive <= 1'b0;
      txTone     <= 1'b0;
      toneClk    <= '0;
      halfIdx    <= '0;
    end else if (stb.accept) begin
      toneActive <= 1'b1;
      txTone     <= 1'b1;
      toneClk    <= '0;
      halfIdx    <= '0;
    end else if (burstDone) begin
      toneActive <= 1'b0;
      txTone     <= 1'b0;
      toneClk    <= '0;
      halfIdx    <= '0;
    end else if (halfEnd) begin
      txTone  <= ~txTone;
      toneClk <= '0;
      halfIdx <= halfIdx + 1'b1;
    end else if (toneActive) begin
      toneClk <= toneClk + 1'b1;
    end
  end

  // echo width counter in clocks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 echoCnt <= '0;
    else if (stb.loadEcho)                     echoCnt <= echoLoad;
    else if (stb.countEcho && echoCnt != '0)   echoCnt <= echoCnt - 1'b1;
  end

  assign echoLast = (echoCnt == EW'(1));
endmodule

// File: rtl/ultra_echo_emu.sv
module ultra_echo_emu
  import ultra_pkg::*;
#(
  parameter int DIST_W        = 9,
  parameter int CLK_PER_US    = 50,
  parameter int MIN_TRIG_US   = 10,
  parameter int TONE_HALF_CLK = 625,
  parameter int TONE_CYCLES   = 8,
  parameter int CM_US         = 58,
  parameter int IN_US         = 148,
  parameter int TIMEOUT_US    = 38000,
  parameter int GUARD_US      = 60000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigIn,
  input  logic [DIST_W-1:0] distIn,
  input  logic              unitInch,
  input  logic              noObstacle,
  output logic              echoOut,
  output logic              txTone,
  output logic              busy,
  output logic              measDone
);
  ctrlStb_t stb;
  logic usTick, burstDone, echoLast;

  ultra_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk(clk), .rstN(rstN), .usTick(usTick)
  );

  ultra_ctrl #(.MIN_TRIG_US(MIN_TRIG_US), .GUARD_US(GUARD_US)) u_ctrl (
    .clk(clk), .rstN(rstN), .usTick(usTick), .trigIn(trigIn),
    .burstDone(burstDone), .echoLast(echoLast), .stb(stb),
    .busy(busy), .echoOn(echoOut), .doneStb(measDone)
  );

  ultra_dpath #(
    .DIST_W(DIST_W), .CLK_PER_US(CLK_PER_US), .TONE_HALF_CLK(TONE_HALF_CLK),
    .TONE_CYCLES(TONE_CYCLES), .CM_US(CM_US), .IN_US(IN_US),
    .TIMEOUT_US(TIMEOUT_US)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .distIn(distIn), .unitInch(unitInch),
    .noObstacle(noObstacle), .txTone(txTone), .burstDone(burstDone),
    .echoLast(echoLast)
  );
endmodule

// File: rtl/ultra_echo_emu_chk.sv
module ultra_echo_emu_chk (
  input logic clk,
  input logic rstN,
  input logic echoOut,
  input logic txTone,
  input logic busy,
  input logic measDone
);
  assert_echo_in_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    echoOut |-> busy);

  assert_tone_in_burst_R3: assert property (@(posedge clk) disable iff (!rstN)
    txTone |-> (busy && !echoOut));

  assert_busy_starts_tone_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> txTone);

  assert_done_after_echo_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(echoOut) |-> measDone);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    measDone |=> !measDone);

  assert_busy_ends_with_echo_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $fell(echoOut));
endmodule

bind ultra_echo_emu ultra_echo_emu_chk u_chk (
  .clk(clk), .rstN(rstN), .echoOut(echoOut), .txTone(txTone),
  .busy(busy), .measDone(measDone)
);

// File: tb/ultra_echo_emu_tb.sv
module ultra_echo_emu_tb;
  localparam int CPU   = 2;
  localparam int HALF  = 10;
  localparam int NTONE = 8;
  localparam int GUARD = 600;
  localparam int TOUT  = 300;
  localparam int NV    = 6;

  // {noObstacle, unitInch, distIn} and expected echo clocks
  localparam logic [10:0] STIM [NV] = '{
    {1'b0, 1'b0, 9'd2}, {1'b0, 1'b0, 9'd5}, {1'b0, 1'b1, 9'd1},
    {1'b0, 1'b1, 9'd3}, {1'b1, 1'b0, 9'd7}, {1'b0, 1'b0, 9'd0}
  };
  localparam int EXPW [NV] = '{232, 580, 296, 888, 600, 116};

  logic clk = 1'b0, rstN = 1'b0, trigIn = 1'b0;
  logic [8:0] distIn = 9'd0;
  logic unitInch = 1'b0, noObstacle = 1'b0;
  logic echoOut, txTone, busy, measDone;

  int nChk = 0, nBad = 0;
  int toneRise, toneHigh, burstLen, echoLen;
  bit gotBusy, doneOk;

  always #10 clk = ~clk;

  ultra_echo_emu #(
    .CLK_PER_US(CPU), .TONE_HALF_CLK(HALF), .TONE_CYCLES(NTONE),
    .TIMEOUT_US(TOUT), .GUARD_US(GUARD)
  ) u_dut (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .distIn(distIn),
    .unitInch(unitInch), .noObstacle(noObstacle), .echoOut(echoOut),
    .txTone(txTone), .busy(busy), .measDone(measDone)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  task automatic pulseTrig(input int us);
    @(negedge clk) trigIn = 1'b1;
    repeat (us * CPU) @(negedge clk);
    trigIn = 1'b0;
  endtask

  task automatic waitNoBusy(input int cyc, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (busy) seen = 1'b1;
    end
  endtask

  task automatic measure();
    bit prevTone;
    int c;
    toneRise = 0; toneHigh = 0; burstLen = 0; echoLen = 0; doneOk = 1'b0;
    c = 0;
    while (!busy && c < 40) begin @(negedge clk); c++; end
    gotBusy = busy;
    if (!gotBusy) return;
    prevTone = 1'b0;
    while (!echoOut) begin
      burstLen++;
      if (txTone) toneHigh++;
      if (txTone && !prevTone) toneRise++;
      prevTone = txTone;
      @(negedge clk);
    end
    while (echoOut) begin echoLen++; @(negedge clk); end
    doneOk = measDone && !busy;
    @(negedge clk);
    doneOk = doneOk && !measDone;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishRun();
  end

  initial begin
    bit seen;
    repeat (3) @(negedge clk);
    // R1 reset state
    check({echoOut, txTone, busy, measDone} == 4'b0, "R1", {echoOut, txTone, busy, measDone}, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check({echoOut, txTone, busy, measDone} == 4'b0, "R1", {echoOut, txTone, busy, measDone}, 0);

    // R2 short pulse rejected
    pulseTrig(5);
    waitNoBusy(60, seen);
    check(!seen, "R2 short", seen, 0);

    // table: R3 R4 R5 R6 R11 and R10
    for (int v = 0; v < NV; v++) begin
      {noObstacle, unitInch, distIn} = STIM[v];
      pulseTrig(15);
      measure();
      check(gotBusy, "R2 accept", gotBusy, 1);
      check(toneRise == NTONE, "R3 tones", toneRise, NTONE);
      check(toneHigh == NTONE * HALF && burstLen == 2 * NTONE * HALF, "R3 burst",
            burstLen, 2 * NTONE * HALF);
      check(echoLen == EXPW[v], v == 4 ? "R6" : (v == 5 ? "R11" : (unitInch ? "R5" : "R4")),
            echoLen, EXPW[v]);
      check(doneOk, "R10 done", doneOk, 1);
      repeat (GUARD * CPU + 20) @(negedge clk);
    end

    // R7 latched inputs, R8 trigger while busy
    {noObstacle, unitInch, distIn} = {1'b0, 1'b0, 9'd4};
    pulseTrig(15);
    fork
      measure();
      begin
        repeat (20) @(negedge clk);
        distIn = 9'd9; unitInch = 1'b1; noObstacle = 1'b1;
        pulseTrig(15);
      end
    join
    check(echoLen == 464, "R7", echoLen, 464);
    waitNoBusy(40, seen);
    check(!seen, "R8 busy", seen, 0);

    // R8 guard after completion, then R9
    {noObstacle, unitInch, distIn} = {1'b0, 1'b0, 9'd2};
    repeat (GUARD * CPU + 20) @(negedge clk);
    pulseTrig(15);
    measure();
    check(echoLen == 232, "R4", echoLen, 232);
    pulseTrig(15);
    waitNoBusy(40, seen);
    check(!seen, "R8 guard", seen, 0);
    pulseTrig(5);
    repeat (420 * CPU) @(negedge clk);
    pulseTrig(15);
    measure();
    check(gotBusy, "R9", gotBusy, 1);
    check(echoLen == 232, "R9 echo", echoLen, 232);

    finishRun();
  end
endmodule